// File: doc/BRIEF.md
# FIFO-Aware DMA Request Arbiter

This block sits in front of a single bus master port that is shared by a receive DMA engine and a transmit DMA engine. Each engine raises a request line when it wants the port. The arbiter answers with a one-hot pair of registered grants. A grant stays with its owner for as long as that owner keeps its request high, which normally covers one burst.

When only one engine is asking, that engine gets the port. When both ask in the same idle cycle, the arbiter compares two live FIFO figures and serves the side that is closer to trouble. These figures are the number of valid bytes waiting in the transmit FIFO and the number of free bytes left in the receive FIFO. Transmit wins only when its valid byte count is strictly below the receive free byte count. Otherwise receive wins, so an equal comparison goes to receive.

Both FIFOs hold `FIFO_BYTES` bytes. Each count therefore spans 0 to `FIFO_BYTES` inclusive and is carried on a port wide enough for the full value. With the default of 256 bytes, the ports are 9 bits wide.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `rx_gnt` and `tx_gnt` are 0.
- R2: If neither request is high while no grant is active, both grants are 0 after the next rising clock edge.
- R3: If only `tx_req` is high while no grant is active, `tx_gnt` is 1 and `rx_gnt` is 0 one clock later.
- R4: If only `rx_req` is high while no grant is active, `rx_gnt` is 1 and `tx_gnt` is 0 one clock later.
- R5: If both requests are high while no grant is active, and `tx_valid_bytes` < `rx_free_bytes` (unsigned), `tx_gnt` is 1 one clock later.
- R6: If both requests are high while no grant is active, and `rx_free_bytes` <= `tx_valid_bytes` (unsigned, ties included), `rx_gnt` is 1 one clock later.
- R7: While a grant is active and its own request stays high, the grant holds. A competing request, or any change to either count, does not move it.
- R8: When the granted engine drops its request, both grants are 0 after the next edge. That idle cycle is sampled before any new grant is issued, so the earliest new grant comes one clock after it.
- R9: `rx_gnt` and `tx_gnt` are never 1 together.
- R10: The comparison uses the full count width, so the values `FIFO_BYTES` and `FIFO_BYTES-1` are told apart correctly at both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 1 | Bus request from the receive DMA engine |
| tx_req | input | 1 | Bus request from the transmit DMA engine |
| tx_valid_bytes | input | CNT_W | Valid bytes currently held in the transmit FIFO |
| rx_free_bytes | input | CNT_W | Free bytes currently left in the receive FIFO |
| rx_gnt | output | 1 | Registered grant to the receive engine |
| tx_gnt | output | 1 | Registered grant to the transmit engine |

## Verification
Two events can land in the same cycle: a grant being released, and a competing request (or a swing in the counts) arriving. The bench provokes this by keeping the loser's request high while the counts flip in favour of the loser, and then dropping the owner's request. The arbiter must first keep the original owner (R7) and then leave exactly one idle cycle (R8). After that idle cycle it must grant the waiting engine. Both grants are also checked at every sample to confirm they are never high together.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int FIFO_BYTES = 256,
  parameter int CNT_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic [CNT_W-1:0] tx_valid_bytes,
  input  logic [CNT_W-1:0] rx_free_bytes,
  output logic             rx_gnt,
  output logic             tx_gnt
);

  logic busy;
  logic tx_first;
  logic pick_tx;
  logic pick_rx;

  assign busy     = rx_gnt | tx_gnt;
  assign tx_first = tx_valid_bytes < rx_free_bytes;
  assign pick_tx  = tx_req & (~rx_req | tx_first);
  assign pick_rx  = rx_req & (~tx_req | ~tx_first);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_gnt <= 1'b0;
      tx_gnt <= 1'b0;
    end else if (busy) begin
      rx_gnt <= rx_gnt & rx_req;
      tx_gnt <= tx_gnt & tx_req;
    end else begin
      rx_gnt <= pick_rx;
      tx_gnt <= pick_tx;
    end
  end

  // R9
  one_hot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_gnt && tx_gnt));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt && tx_req |=> tx_gnt);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gnt && rx_req |=> rx_gnt);

  // R8
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && !tx_req) || (rx_gnt && !rx_req) |=> !tx_gnt && !rx_gnt);

  // R6
  tie_to_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_gnt && !rx_gnt && rx_req && tx_req && (rx_free_bytes <= tx_valid_bytes)
    |=> rx_gnt);

  // R5
  tx_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_gnt && !rx_gnt && rx_req && tx_req && (tx_valid_bytes < rx_free_bytes)
    |=> tx_gnt);

  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_gnt && !rx_gnt && !rx_req && !tx_req |=> !tx_gnt && !rx_gnt);

endmodule

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
  localparam int FB = 256;
  localparam int W  = $clog2(FB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_req = 1'b0, tx_req = 1'b0;
  logic [W-1:0] tx_valid_bytes = '0, rx_free_bytes = '0;
  logic rx_gnt, tx_gnt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_req_arbiter #(.FIFO_BYTES(FB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
    .tx_valid_bytes(tx_valid_bytes), .rx_free_bytes(rx_free_bytes),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt));

  task automatic chk(input string req, input logic exp_rx, input logic exp_tx);
    checks++;
    if (rx_gnt !== exp_rx || tx_gnt !== exp_tx) begin
      errors++;
      $display("FAIL %s: rx_gnt=%b tx_gnt=%b expected rx_gnt=%b tx_gnt=%b",
               req, rx_gnt, tx_gnt, exp_rx, exp_tx);
    end
    checks++;
    if (rx_gnt === 1'b1 && tx_gnt === 1'b1) begin
      errors++;
      $display("FAIL R9: both grants high, actual 11 expected at most one");
    end
  endtask

  task automatic drive(input logic r, input logic t, input int tv, input int rf);
    @(negedge clk);
    rx_req = r; tx_req = t;
    tx_valid_bytes = W'(tv); rx_free_bytes = W'(rf);
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic release_all;
    drive(0, 0, 0, 0);
    step();
    chk("R8", 0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1", 0, 0);
    @(negedge clk) rst_n = 1'b1;
    step();
    chk("R1", 0, 0);
  endtask

  task automatic t_idle;
    drive(0, 0, 40, 40);
    step(); chk("R2", 0, 0);
    step(); chk("R2", 0, 0);
  endtask

  task automatic t_single;
    drive(0, 1, 0, 0);
    step(); chk("R3", 0, 1);
    release_all();
    drive(1, 0, 256, 256);
    step(); chk("R4", 1, 0);
    release_all();
  endtask

  task automatic t_both_hold_release;
    drive(1, 1, 10, 200);
    step(); chk("R5", 0, 1);
    drive(1, 1, 200, 10);
    step(); chk("R7", 0, 1);
    step(); chk("R7", 0, 1);
    drive(1, 0, 200, 10);
    step(); chk("R8", 0, 0);
    step(); chk("R8", 1, 0);
    drive(1, 1, 0, 256);
    step(); chk("R7", 1, 0);
    release_all();
  endtask

  task automatic t_tie;
    drive(1, 1, 100, 100);
    step(); chk("R6", 1, 0);
    release_all();
    drive(1, 1, 0, 0);
    step(); chk("R6", 1, 0);
    release_all();
  endtask

  task automatic t_bounds;
    drive(1, 1, 255, 256);
    step(); chk("R10", 0, 1);
    release_all();
    drive(1, 1, 256, 255);
    step(); chk("R10", 1, 0);
    release_all();
    drive(1, 1, 0, 256);
    step(); chk("R10", 0, 1);
    release_all();
    drive(1, 1, 256, 256);
    step(); chk("R10", 1, 0);
    release_all();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_both_hold_release();
    t_tie();
    t_bounds();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule